// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single peripheral data-movement channel. It copies data words between one peripheral data register and system memory without processor help. Software loads two descriptors, each made of a start pointer and a transfer count: the active ("current") one and a queued ("next") one. Each ready strobe from the peripheral asks for one transfer. The channel then raises a bus request and, once granted, performs a single-beat read followed by a single-beat write. After that it advances the memory pointer by the word size and lowers the remaining count.

When the active count runs out while a queued count is waiting, the queued descriptor moves into the active slot in the same clock edge. Streaming therefore carries on with no idle gap, and the queued count is cleared. A parameter sets the direction. In the receive variant the channel reads the peripheral register and writes memory. In the transmit variant it reads memory and writes the peripheral register. Two flags report progress: one for "active buffer finished" and one for "both buffers empty". Either flag drives the interrupt line, and a level output tells the peripheral that no block is loaded.

Top module: `pdma_channel`

## Requirements
- R1: Out of reset, both descriptors are zero, `bus_req` and `bus_valid` are low, `end_buf` is low, and `buf_full`, `irq` and `periph_eob` are high.
- R2: A write strobe `cfg_we` loads `cfg_wdata` into the field chosen by `cfg_sel`: code 0 = active pointer, 1 = active count, 2 = queued pointer, 3 = queued count. The new value takes effect at the next clock edge.
- R3: Receive variant (`IS_RX`=1): a ready pulse sampled at edge t with a nonzero active count drives `bus_req` high after edge t+1. After `bus_gnt`, the channel issues a read beat (`bus_we`=0) at `PERIPH_ADDR`, then a write beat (`bus_we`=1) at the active pointer that carries the data returned by the read. Each beat ends on `bus_ack`.
- R4: Transmit variant (`IS_RX`=0): the read beat goes to the active pointer and the write beat goes to `PERIPH_ADDR`, carrying the data that was read.
- R5: Each completed transfer adds `XFER_BYTES` (1, 2 or 4) to the active pointer and subtracts one from the active count. `bus_req` stays high from the request until the write beat is acknowledged.
- R6: When the active count is zero and the queued count is nonzero, in the same edge the queued pointer and count become the active ones and the queued count becomes zero. The next transfer then uses the queued pointer, with no gap.
- R7: `end_buf` sets when a transfer takes the active count to zero. A write of either count field (code 1 or 3) clears it.
- R8: `buf_full` is high exactly when both counts are zero. `irq` is `end_buf` OR `buf_full`. `periph_eob` is high exactly when the active count is zero.
- R9: A ready pulse that arrives while a transfer is in progress is held and serviced after that transfer. Several such pulses during one transfer merge into a single further transfer.
- R10: Ready pulses are ignored while the active count is zero. They raise no request and are not kept for later, even after a count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Field select (0 act ptr, 1 act cnt, 2 queued ptr, 3 queued cnt) |
| cfg_wdata | input | ADDR_W | Write data; counts take the low CNT_W bits |
| periph_rdy | input | 1 | Peripheral ready pulse, one transfer request |
| periph_eob | output | 1 | No active block loaded (active count zero) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_valid | output | 1 | Beat valid |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | DATA_W | Write beat data |
| bus_rdata | input | DATA_W | Read beat data, taken with bus_ack |
| bus_ack | input | 1 | Beat complete |
| end_buf | output | 1 | Active buffer finished flag |
| buf_full | output | 1 | Both counts zero flag |
| irq | output | 1 | Interrupt request |

## Verification
Descriptor writes are visible at the first falling edge after the edge that applies them. The bench checks count-related flags there. The request answers a ready pulse two rising edges after the pulse is first sampled, so the bench samples `bus_req` low one falling edge after the pulse and high on the falling edge after that. Bus beats are checked at the falling edge where the bench answers with `bus_ack`, because address, direction and data are held steady until that acknowledge. The bench's own descriptor model advances at those same points. The flag and interrupt checks on the buffer state are made only after the request line has been low for several cycles, so that random grant and acknowledge delays cannot move the sampling point.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        SEL_CUR_PTR = 2'd0,
        SEL_CUR_CNT = 2'd1,
        SEL_NXT_PTR = 2'd2,
        SEL_NXT_CNT = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR
    } seq_state_e;

    typedef struct packed {
        logic end_buf;
        logic buf_full;
    } chan_flags_t;

    function automatic bit size_ok(int unsigned b);
        return (b == 1) || (b == 2) || (b == 4);
    endfunction

    function automatic bit writes_count(cfg_sel_e s);
        return (s == SEL_CUR_CNT) || (s == SEL_NXT_CNT);
    endfunction

endpackage

// File: rtl/pdma_desc_regs.sv
module pdma_desc_regs
    import pdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int XFER_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  cfg_sel_e          cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              end_buf
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(XFER_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    logic [ADDR_W-1:0] nxt_ptr;
    logic [ADDR_W-1:0] c_ptr_d, n_ptr_d;
    logic [CNT_W-1:0]  c_cnt_d, n_cnt_d;
    logic              end_set, end_clr;

    always_comb begin
        c_ptr_d = cur_ptr;
        c_cnt_d = cur_cnt;
        n_ptr_d = nxt_ptr;
        n_cnt_d = nxt_cnt;
        end_set = 1'b0;
        end_clr = 1'b0;
        // one transfer retired
        if (xfer_done && (cur_cnt != '0)) begin
            c_ptr_d = cur_ptr + STEP;
            c_cnt_d = cur_cnt - ONE;
            end_set = (cur_cnt == ONE);
        end
        // software write overrides the addressed field
        if (cfg_we) begin
            end_clr = writes_count(cfg_sel);
            case (cfg_sel)
                SEL_CUR_PTR: c_ptr_d = cfg_wdata;
                SEL_CUR_CNT: c_cnt_d = cfg_wdata[CNT_W-1:0];
                SEL_NXT_PTR: n_ptr_d = cfg_wdata;
                default:     n_cnt_d = cfg_wdata[CNT_W-1:0];
            endcase
        end
        // seamless takeover of the queued descriptor
        if ((c_cnt_d == '0) && (n_cnt_d != '0)) begin
            c_ptr_d = n_ptr_d;
            c_cnt_d = n_cnt_d;
            n_cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ptr <= '0;
            cur_cnt <= '0;
            nxt_ptr <= '0;
            nxt_cnt <= '0;
            end_buf <= 1'b0;
        end else begin
            cur_ptr <= c_ptr_d;
            cur_cnt <= c_cnt_d;
            nxt_ptr <= n_ptr_d;
            nxt_cnt <= n_cnt_d;
            end_buf <= end_clr ? 1'b0 : (end_buf | end_set);
        end
    end

endmodule

// File: rtl/pdma_xfer_seq.sv
module pdma_xfer_seq
    import pdma_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter bit                IS_RX       = 1'b1,
    parameter logic [ADDR_W-1:0] PERIPH_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              periph_rdy,
    input  logic              cnt_nz,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              xfer_done
);

    seq_state_e        state_q, state_d;
    logic              pend_q, start;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    generate
        if (IS_RX) begin : g_rx
            assign rd_addr = PERIPH_ADDR;
            assign wr_addr = cur_ptr;
        end else begin : g_tx
            assign rd_addr = cur_ptr;
            assign wr_addr = PERIPH_ADDR;
        end
    endgenerate

    assign start = (state_q == ST_IDLE) && pend_q && cnt_nz;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start)   state_d = ST_REQ;
            ST_REQ:  if (bus_gnt) state_d = ST_RD;
            ST_RD:   if (bus_ack) state_d = ST_WR;
            default: if (bus_ack) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= cnt_nz & ((pend_q & ~start) | periph_rdy);
            if ((state_q == ST_RD) && bus_ack) data_q <= bus_rdata;
        end
    end

    assign bus_req   = (state_q != ST_IDLE);
    assign bus_valid = (state_q == ST_RD) || (state_q == ST_WR);
    assign bus_we    = (state_q == ST_WR);
    assign bus_addr  = bus_we ? wr_addr : rd_addr;
    assign bus_wdata = data_q;
    assign xfer_done = (state_q == ST_WR) && bus_ack;

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                CNT_W       = 16,
    parameter int                DATA_W      = 32,
    parameter int                XFER_BYTES  = 4,
    parameter bit                IS_RX       = 1'b1,
    parameter logic [ADDR_W-1:0] PERIPH_ADDR = 32'hFFFF_F018
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              periph_rdy,
    output logic              periph_eob,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              end_buf,
    output logic              buf_full,
    output logic              irq
);

    generate
        if (!size_ok(XFER_BYTES)) begin : g_bad_size
            $error("XFER_BYTES must be 1, 2 or 4");
        end
    endgenerate

    logic [ADDR_W-1:0] cur_ptr;
    logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
    logic              xfer_done, end_q;
    chan_flags_t       flags;

    pdma_desc_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)
    ) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel_e'(cfg_sel)), .cfg_wdata(cfg_wdata),
        .xfer_done(xfer_done),
        .cur_ptr(cur_ptr), .cur_cnt(cur_cnt), .nxt_cnt(nxt_cnt),
        .end_buf(end_q)
    );

    pdma_xfer_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_RX(IS_RX), .PERIPH_ADDR(PERIPH_ADDR)
    ) u_seq (
        .clk(clk), .rst(rst),
        .periph_rdy(periph_rdy), .cnt_nz(cur_cnt != '0), .cur_ptr(cur_ptr),
        .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .xfer_done(xfer_done)
    );

    always_comb begin
        flags.end_buf  = end_q;
        flags.buf_full = (cur_cnt == '0) && (nxt_cnt == '0);
    end

    assign end_buf    = flags.end_buf;
    assign buf_full   = flags.buf_full;
    assign irq        = flags.end_buf | flags.buf_full;
    assign periph_eob = (cur_cnt == '0);

endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int XFER_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic              bus_req,
    input logic              bus_valid,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [CNT_W-1:0]  nxt_cnt,
    input logic              end_buf
);

    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(XFER_BYTES);

    logic cnt_write;
    assign cnt_write = cfg_we && ((cfg_sel == 2'd1) || (cfg_sel == 2'd3));

    assert_valid_in_req_R3: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_req);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !xfer_done) |=> bus_req);

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !cfg_we && (cur_cnt > ONE)) |=>
        ((cur_cnt == $past(cur_cnt) - ONE) && (cur_ptr == $past(cur_ptr) + STEP)));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !cfg_we && (cur_cnt == ONE) && (nxt_cnt != '0)) |=>
        ((cur_cnt == $past(nxt_cnt)) && (nxt_cnt == '0)));

    assert_end_set_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !cfg_we && (cur_cnt == ONE)) |=> end_buf);

    assert_end_clr_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_write |=> !end_buf);

    assert_no_req_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && (cur_cnt == '0) && !cfg_we) |=> !bus_req);

endmodule

bind pdma_channel pdma_channel_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .bus_req(bus_req), .bus_valid(bus_valid), .xfer_done(xfer_done),
    .cur_ptr(cur_ptr), .cur_cnt(cur_cnt), .nxt_cnt(nxt_cnt), .end_buf(end_buf)
);

// File: tb/pdma_channel_bench.sv
`timescale 1ns/1ps
module pdma_channel_bench;

    localparam logic [31:0] PA = 32'hFFFF_F018;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we[2];
    logic [1:0]  cfg_sel[2];
    logic [31:0] cfg_wd[2];
    logic        rdy[2], eob[2], req[2], gnt[2], vld[2], we[2], ack[2];
    logic        endb[2], full[2], irq[2];
    logic [31:0] addr[2], wdat[2], rdat[2];

    logic [31:0] m_cptr[2], m_nptr[2], m_last[2];
    int          m_ccnt[2], m_ncnt[2], m_xfers[2];
    bit          m_end[2];
    int          n_cmp = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    pdma_channel #(.IS_RX(1'b1), .PERIPH_ADDR(PA)) u_pdma_channel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we[0]), .cfg_sel(cfg_sel[0]), .cfg_wdata(cfg_wd[0]),
        .periph_rdy(rdy[0]), .periph_eob(eob[0]), .bus_req(req[0]), .bus_gnt(gnt[0]),
        .bus_valid(vld[0]), .bus_we(we[0]), .bus_addr(addr[0]), .bus_wdata(wdat[0]),
        .bus_rdata(rdat[0]), .bus_ack(ack[0]), .end_buf(endb[0]), .buf_full(full[0]), .irq(irq[0]));

    pdma_channel #(.IS_RX(1'b0), .PERIPH_ADDR(PA)) u_pdma_channel_tx (
        .clk(clk), .rst(rst), .cfg_we(cfg_we[1]), .cfg_sel(cfg_sel[1]), .cfg_wdata(cfg_wd[1]),
        .periph_rdy(rdy[1]), .periph_eob(eob[1]), .bus_req(req[1]), .bus_gnt(gnt[1]),
        .bus_valid(vld[1]), .bus_we(we[1]), .bus_addr(addr[1]), .bus_wdata(wdat[1]),
        .bus_rdata(rdat[1]), .bus_ack(ack[1]), .end_buf(endb[1]), .buf_full(full[1]), .irq(irq[1]));

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic m_reload(input int i);
        if (m_ccnt[i] == 0 && m_ncnt[i] != 0) begin
            m_cptr[i] = m_nptr[i];
            m_ccnt[i] = m_ncnt[i];
            m_ncnt[i] = 0;
        end
    endtask

    // bus responder and descriptor model
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                gnt[i] = 1'b0; ack[i] = 1'b0; rdat[i] = '0;
            end else begin
                gnt[i] = req[i] && (gnt[i] || ($urandom % 3 != 0));
                if (ack[i]) ack[i] = 1'b0;
                else if (vld[i] && ($urandom % 2 == 0)) begin
                    if (!we[i]) begin
                        chk(addr[i] == ((i == 0) ? PA : m_cptr[i]), (i == 0) ? "R3" : "R4",
                            "read beat address", addr[i], (i == 0) ? PA : m_cptr[i]);
                        rdat[i]   = $urandom;
                        m_last[i] = rdat[i];
                    end else begin
                        chk(addr[i] == ((i == 0) ? m_cptr[i] : PA), "R5/R6",
                            "write beat address", addr[i], (i == 0) ? m_cptr[i] : PA);
                        chk(wdat[i] == m_last[i], (i == 0) ? "R3" : "R4",
                            "write beat data", wdat[i], m_last[i]);
                        chk(m_ccnt[i] > 0, "R10", "transfer with empty count", 1, 0);
                        m_cptr[i] = m_cptr[i] + 32'd4;
                        if (m_ccnt[i] > 0) m_ccnt[i]--;
                        if (m_ccnt[i] == 0) m_end[i] = 1'b1;
                        m_reload(i);
                        m_xfers[i]++;
                    end
                    ack[i] = 1'b1;
                end
            end
        end
    end

    task automatic cfg_write(input int i, input int sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we[i] = 1'b1; cfg_sel[i] = 2'(sel); cfg_wd[i] = val;
        case (sel)
            0: m_cptr[i] = val;
            1: begin m_ccnt[i] = int'(val[15:0]); m_end[i] = 1'b0; end
            2: m_nptr[i] = val;
            default: begin m_ncnt[i] = int'(val[15:0]); m_end[i] = 1'b0; end
        endcase
        m_reload(i);
        @(negedge clk);
        cfg_we[i] = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); rdy[i] = 1'b1;
        @(negedge clk); rdy[i] = 1'b0;
    endtask

    task automatic wait_idle(input int i);
        int quiet = 0;
        while (quiet < 6) begin
            @(negedge clk);
            if (req[i]) quiet = 0; else quiet++;
        end
    endtask

    task automatic chk_status(input int i, input string rq);
        bit ef = (m_ccnt[i] == 0) && (m_ncnt[i] == 0);
        chk(endb[i] == m_end[i], rq, "end_buf", 32'(endb[i]), 32'(m_end[i]));
        chk(full[i] == ef, "R8", "buf_full", 32'(full[i]), 32'(ef));
        chk(irq[i] == (ef | m_end[i]), "R8", "irq", 32'(irq[i]), 32'(ef | m_end[i]));
        chk(eob[i] == (m_ccnt[i] == 0), "R8", "periph_eob", 32'(eob[i]), 32'(m_ccnt[i] == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2; i++) begin
            cfg_we[i] = 0; cfg_sel[i] = 0; cfg_wd[i] = 0; rdy[i] = 0;
            m_cptr[i] = 0; m_nptr[i] = 0; m_last[i] = 0;
            m_ccnt[i] = 0; m_ncnt[i] = 0; m_xfers[i] = 0; m_end[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 2; i++) begin
            chk(!req[i] && !vld[i], "R1", "bus idle after reset", 32'(req[i]), 0);
            chk(!endb[i] && full[i] && irq[i] && eob[i], "R1", "flags after reset",
                {endb[i], full[i], irq[i], eob[i]}, 32'b0111);
        end

        // R10: strobe with empty count is ignored and not remembered
        pulse(0);
        begin
            bit seen = 1'b0;
            repeat (6) begin @(negedge clk); if (req[0]) seen = 1'b1; end
            chk(!seen, "R10", "request with empty count", 32'(seen), 0);
        end
        cfg_write(0, 0, 32'h0000_1000);
        cfg_write(0, 1, 32'd3);
        chk_status(0, "R2");
        repeat (6) @(negedge clk);
        chk(m_xfers[0] == 0 && !req[0], "R10", "stale strobe serviced", m_xfers[0], 0);

        // R3 request timing
        @(negedge clk); rdy[0] = 1'b1;
        @(negedge clk); rdy[0] = 1'b0;
        chk(!req[0], "R3", "bus_req one cycle after pulse", 32'(req[0]), 0);
        @(negedge clk);
        chk(req[0], "R3", "bus_req two cycles after pulse", 32'(req[0]), 1);
        wait_idle(0);
        chk(m_xfers[0] == 1, "R3", "transfers after one pulse", m_xfers[0], 1);
        chk_status(0, "R5");

        // R9: pulses during a transfer merge into one
        base = m_xfers[0];
        pulse(0); pulse(0); pulse(0);
        wait_idle(0);
        chk(m_xfers[0] - base == 2, "R9", "transfers from three close pulses", m_xfers[0] - base, 2);
        chk_status(0, "R7");
        chk(endb[0], "R7", "end_buf at count zero", 32'(endb[0]), 1);

        // R7 clear by count write, R6 immediate takeover
        cfg_write(0, 2, 32'h0000_2000);
        cfg_write(0, 3, 32'd2);
        chk_status(0, "R7");
        chk(!eob[0], "R6", "queued block taken over", 32'(eob[0]), 0);
        cfg_write(0, 2, 32'h0000_3000);
        cfg_write(0, 3, 32'd1);
        pulse(0); wait_idle(0);
        pulse(0); wait_idle(0);
        chk_status(0, "R7");
        chk(endb[0] && !eob[0], "R6", "no gap at buffer switch", {endb[0], eob[0]}, 32'b10);
        pulse(0); wait_idle(0);
        chk_status(0, "R6");
        base = m_xfers[0];
        pulse(0); wait_idle(0);
        chk(m_xfers[0] == base, "R6", "queued count cleared on takeover", m_xfers[0], base);

        // R4 transmit variant
        cfg_write(1, 0, 32'h0000_4000);
        cfg_write(1, 1, 32'd2);
        pulse(1); wait_idle(1);
        pulse(1); wait_idle(1);
        chk(m_xfers[1] == 2, "R4", "transmit transfers", m_xfers[1], 2);
        chk_status(1, "R7");

        // random mix on the receive channel
        for (int k = 0; k < 40; k++) begin
            if (m_ccnt[0] == 0 && ($urandom % 2 == 0)) begin
                cfg_write(0, 0, $urandom & 32'h00FF_FFFC);
                cfg_write(0, 1, 32'(1 + $urandom % 4));
            end
            if (m_ncnt[0] == 0 && ($urandom % 3 == 0)) begin
                cfg_write(0, 2, $urandom & 32'h00FF_FFFC);
                cfg_write(0, 3, 32'(1 + $urandom % 4));
            end
            for (int p = 0; p < 1 + int'($urandom % 3); p++) begin
                pulse(0);
                repeat ($urandom % 4) @(negedge clk);
            end
            wait_idle(0);
            chk_status(0, "R7");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule